// File: doc/BRIEF.md
# Two-slot elastic pipeline buffer

This block is one registered stage on a synchronous elastic channel. Each side of the channel carries a data word, a valid flag and a stop flag, and a word moves across a side only in a cycle where valid is high and stop is low. A word taken in from upstream shows up at the downstream side on the next cycle. The stage can hold two words: a main slot that feeds the output, and an auxiliary slot.

The auxiliary slot lets the stage drive its upstream stop flag from a flop instead of passing the downstream stop through. Back-pressure from downstream reaches the upstream side one cycle late. The word that upstream launches in that cycle goes into the auxiliary slot, so it is not lost. When downstream stops taking words, the stage holds its output steady.

At reset the stage either starts empty or holds one live word with a value set by a parameter. With that, chains of these stages can be built into rings that start with tokens in them.

Top module: `elastic_buf2`

## Requirements
- R1: While reset is low and on the first cycle after reset, valid_o equals INIT_TOKEN, stop_o is 0 and, when INIT_TOKEN is 1, data_o equals INIT_DATA.
- R2: An input word is taken only at a rising edge where valid_i is 1 and stop_o is 0. An output word is consumed only at a rising edge where valid_o is 1 and stop_i is 0.
- R3: A word taken while the stage is empty is on data_o, with valid_o high, in the cycle right after the edge that took it in.
- R4: While valid_o is 1 and stop_i is 1, valid_o and data_o keep their values at the next edge.
- R5: stop_o is 1 exactly when the stage holds two words. The stage never holds more than two.
- R6: stop_o comes from a flop. It rises only after an edge that took a word in without sending one out, and it falls only after an edge where stop_i was 0.
- R7: Words leave in the order they arrived. None is dropped and none is duplicated.
- R8: With stop_i held at 0 and valid_i held at 1, one word passes on every cycle, and stop_o stays 0.
- R9: While stop_o is 1, valid_i and data_i have no effect. The held words and the output are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Upstream word present |
| data_i | input | DATA_W | Upstream word |
| stop_o | output | 1 | Back-pressure to upstream; flop-driven |
| valid_o | output | 1 | Downstream word present |
| data_o | output | DATA_W | Downstream word |
| stop_i | input | 1 | Back-pressure from downstream |

## Verification
The hardest case to reach is the full state. To get there, downstream must raise stop while upstream keeps sending, so that a word is in flight at the same moment stop arrives. That full state must then be left by a release while upstream is still trying to push new words. The stimulus reaches it with a directed phase that holds stop_i high under continuous valid_i and changes data_i while the stage is full, then drains the stage. A long stretch of random valid and stop patterns follows, checked cycle by cycle against a queue model, and covers the other ways into and out of the full state.

// File: rtl/elastic_buf2_pkg.sv
package elastic_buf2_pkg;
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_ONE   = 2'd1,
    OCC_TWO   = 2'd2
  } occ_e;
endpackage

// File: rtl/eb_slot.sv
module eb_slot #(
  parameter int          W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= INIT;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/eb_ctrl.sv
module eb_ctrl
  import elastic_buf2_pkg::*;
#(
  parameter bit INIT_TOKEN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic stop_i,
  output logic load_main_o,
  output logic load_aux_o,
  output logic main_from_aux_o,
  output logic valid_o,
  output logic stop_o
);
  localparam occ_e OCC_RST = INIT_TOKEN ? OCC_ONE : OCC_EMPTY;

  occ_e occ_q, occ_d;
  logic full_q;
  logic in_fire, out_fire;

  assign valid_o  = (occ_q != OCC_EMPTY);
  assign stop_o   = full_q;
  assign in_fire  = valid_i && !full_q;
  assign out_fire = valid_o && !stop_i;

  always_comb begin
    occ_d           = occ_q;
    load_main_o     = 1'b0;
    load_aux_o      = 1'b0;
    main_from_aux_o = 1'b0;
    unique case (occ_q)
      OCC_EMPTY: if (in_fire) begin
        load_main_o = 1'b1;
        occ_d       = OCC_ONE;
      end
      OCC_ONE: begin
        if (in_fire && out_fire) begin
          load_main_o = 1'b1;
        end else if (in_fire) begin
          // output stalled: in-flight word parks in aux
          load_aux_o = 1'b1;
          occ_d      = OCC_TWO;
        end else if (out_fire) begin
          occ_d = OCC_EMPTY;
        end
      end
      OCC_TWO: if (out_fire) begin
        load_main_o     = 1'b1;
        main_from_aux_o = 1'b1;
        occ_d           = OCC_ONE;
      end
      default: occ_d = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= OCC_RST;
      full_q <= 1'b0;
    end else begin
      occ_q  <= occ_d;
      full_q <= (occ_d == OCC_TWO);
    end
  end
endmodule

// File: rtl/elastic_buf2.sv
module elastic_buf2 #(
  parameter int               DATA_W     = 16,
  parameter bit               INIT_TOKEN = 1'b1,
  parameter logic [DATA_W-1:0] INIT_DATA = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              stop_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              stop_i
);
  localparam logic [DATA_W-1:0] MAIN_RST = INIT_TOKEN ? INIT_DATA : '0;

  logic              load_main, load_aux, main_from_aux;
  logic [DATA_W-1:0] aux_q, main_d;

  eb_ctrl #(.INIT_TOKEN(INIT_TOKEN)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .valid_i         (valid_i),
    .stop_i          (stop_i),
    .load_main_o     (load_main),
    .load_aux_o      (load_aux),
    .main_from_aux_o (main_from_aux),
    .valid_o         (valid_o),
    .stop_o          (stop_o)
  );

  assign main_d = main_from_aux ? aux_q : data_i;

  eb_slot #(.W(DATA_W), .INIT(MAIN_RST)) u_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_main),
    .d_i    (main_d),
    .q_o    (data_o)
  );

  eb_slot #(.W(DATA_W), .INIT('0)) u_aux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_aux),
    .d_i    (data_i),
    .q_o    (aux_q)
  );
endmodule

// File: rtl/elastic_buf2_chk.sv
module elastic_buf2_chk #(
  parameter int DATA_W     = 16,
  parameter bit INIT_TOKEN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              stop_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic              stop_i
);
  logic [1:0] cnt_q;
  logic in_fire, out_fire;
  assign in_fire  = valid_i && !stop_o;
  assign out_fire = valid_o && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= INIT_TOKEN ? 2'd1 : 2'd0;
    else         cnt_q <= cnt_q + {1'b0, in_fire} - {1'b0, out_fire};
  end

  assert_occ_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= 2'd2) && (stop_o == (cnt_q == 2'd2)));

  assert_valid_occ_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (cnt_q != 2'd0));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stop_i) |=> (valid_o && $stable(data_o)));

  assert_stop_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> $past(in_fire && !out_fire));

  assert_stop_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_o) |-> $past(!stop_i));

  assert_full_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && stop_i) |=> (stop_o && $stable(data_o)));
endmodule

bind elastic_buf2 elastic_buf2_chk #(.DATA_W(DATA_W), .INIT_TOKEN(INIT_TOKEN)) u_chk (.*);

// File: tb/tb_elastic_buf2.sv
module tb_elastic_buf2;
  localparam int          DW    = 16;
  localparam logic [DW-1:0] IDATA = 16'h5A3C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          stop_i = 1'b1;
  logic          stop_o, valid_o;
  logic [DW-1:0] data_o;

  elastic_buf2 #(.DATA_W(DW), .INIT_TOKEN(1'b1), .INIT_DATA(IDATA)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .stop_o(stop_o), .valid_o(valid_o), .data_o(data_o), .stop_i(stop_i)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] q[$];
  logic          p_v = 1'b0, p_s = 1'b1, p_vo = 1'b0;
  logic [DW-1:0] p_d = '0, p_do = '0;
  int            outs = 0;
  logic [DW-1:0] next_word = 16'h0100;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: update model from last inputs, compare, drive new inputs
  task automatic step(input logic v, input logic [DW-1:0] d, input logic s);
    @(negedge clk_i);
    begin
      int sz;
      bit infire, outfire;
      sz = q.size();
      outfire = (sz > 0) && !p_s;
      infire  = p_v && (sz < 2);
      if (outfire) void'(q.pop_front());
      if (infire) q.push_back(p_d);
    end
    chk(valid_o == (q.size() > 0), "R3 valid_o", valid_o, q.size() > 0);
    chk(stop_o == (q.size() == 2), "R5 stop_o", stop_o, q.size() == 2);
    if (q.size() > 0) chk(data_o == q[0], "R7 data_o order", data_o, q[0]);
    if (p_vo && p_s) chk(valid_o && data_o == p_do, "R4 hold under stop", data_o, p_do);
    if (valid_o && !s) outs++;
    valid_i = v; data_i = d; stop_i = s;
    p_v = v; p_d = d; p_s = s; p_vo = valid_o; p_do = data_o;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b1, "R1 reset valid", valid_o, 1);
    chk(stop_o == 1'b0, "R1 reset stop", stop_o, 0);
    chk(data_o == IDATA, "R1 reset data", data_o, IDATA);
    rst_ni = 1'b1;
    q.push_back(IDATA);
    @(negedge clk_i);
    chk(valid_o && data_o == IDATA && !stop_o, "R1 after reset", data_o, IDATA);
    p_v = 0; p_s = 1; p_vo = 1; p_do = IDATA;

    // R5/R4/R9: fill under back-pressure, then disturb inputs while full
    for (int i = 0; i < 4; i++) begin
      step(1'b1, next_word, 1'b1);
      if (!stop_o) next_word++;
    end
    chk(stop_o == 1'b1, "R5 full after stall", stop_o, 1);
    chk(data_o == IDATA, "R9 output unchanged while full", data_o, IDATA);
    for (int i = 0; i < 3; i++) step(1'b1, 16'hDEAD, 1'b1);
    chk(stop_o && data_o == IDATA, "R9 full ignores data_i", data_o, IDATA);
    // R6/R7: release and drain
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b0);
    chk(!valid_o && !stop_o, "R7 drained empty", valid_o, 0);

    // R8: streaming with no back-pressure
    outs = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b1, next_word, 1'b0);
      next_word++;
      if (i > 0) chk(!stop_o, "R8 stop_o low while streaming", stop_o, 0);
    end
    step(1'b0, '0, 1'b0);
    chk(outs == 20, "R8 one word per cycle", outs, 20);
    step(1'b0, '0, 1'b0);

    // R2/R6/R7: random traffic
    for (int i = 0; i < 2000; i++) begin
      logic v, s;
      v = ($urandom_range(0, 3) != 0);
      s = ($urandom_range(0, 2) == 0);
      step(v, v ? next_word : 16'hBEEF, s);
      if (v) next_word++;
    end
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
    chk(q.size() == 0 && !valid_o, "R2 all words delivered", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule